// File: doc/BRIEF.md
# Serial Flash Identification Responder

This block is the identification read path inside the slave side of a serial flash interface. It watches chip select, the serial clock and the serial data input. It decodes three identification opcodes and counts the address or dummy bytes that follow each one. It then shifts the selected identification bytes out, most significant bit first, on falling serial clock edges. The identification values are parameters. An input flag tells the block that a program or erase cycle is running elsewhere in the device.

The serial pins are sampled by the block clock and are assumed to be synchronous to it already. A rising serial clock edge shifts one input bit in. A falling edge shifts one output bit out. The output data is paired with an output enable. The pad is driven only while that enable is high, and at all other times the line is high-impedance.

The controller has five states: `ST_IDLE` (deselected), `ST_OPCODE` (collecting the first byte), `ST_ADDR` (counting address or dummy bytes), `ST_SEND` (streaming ID bytes) and `ST_IGNORE` (selected, but the command is rejected). The transitions are:
- idle to opcode when chip select falls.
- opcode to send for opcode 9Fh when not busy.
- opcode to address for opcode 90h, and for opcode ABh when not busy.
- opcode to ignore for a busy 9Fh, a busy ABh or any other opcode.
- address to send after the last expected byte.
- any state to idle when chip select goes high.

Top module: `fid_responder`

## Requirements
- R1: While chip select (`cs_n`) is high, `so_oe` is 0. Raising `cs_n` ends the current command.
- R2: `so_oe` stays 0 while the opcode byte and any address or dummy bytes are being shifted in. It first goes high on the first falling SCLK edge after the final input bit.
- R3: Opcode 9Fh returns three bytes in this order: `MFR_ID`, `TYPE_ID`, `CAP_ID`. The sequence then wraps back to `MFR_ID` for as long as clocks continue.
- R4: Opcode 9Fh received while `busy` is 1 is not decoded. `so_oe` stays 0 until deselect.
- R5: Opcode 90h followed by three address bytes whose last bit (address bit 0) is 0 returns `MFR_ID` then `DEV_ID`. The two bytes keep alternating.
- R6: Opcode 90h with address bit 0 equal to 1 returns `DEV_ID` first, then `MFR_ID`. The two bytes keep alternating.
- R7: Opcode ABh followed by three dummy bytes returns `DEV_ID`, repeated endlessly.
- R8: Opcode ABh received while `busy` is 1 is ignored. `so_oe` stays 0.
- R9: Each output bit is sent MSB first. It updates one clock after a sampled falling SCLK edge and holds steady until the next falling edge.
- R10: Any opcode other than 9Fh, 90h or ABh produces no output.
- R11: A command aborted mid-byte by raising `cs_n` leaves no residue. The next command starts from its first byte and first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock (synchronous sample) |
| mosi | input | 1 | Serial data in, sampled on rising SCLK |
| busy | input | 1 | Program or erase cycle in progress |
| so_data | output | 1 | Serial data out value |
| so_oe | output | 1 | Pad drive enable; 0 means high-impedance |

## Verification
An output bit is due one block clock after the clock in which a falling SCLK is sampled. The bench keeps each SCLK phase four clocks long and reads `so_data` at the end of the low phase. It reads the same bit again at the end of the high phase, which confirms the value held. The controller needs one clock to decode an opcode after its eighth rising edge. That fits well inside the four-clock gap before the first output fall. The bench samples `so_oe` at every phase of the input bytes and of rejected commands.

// File: rtl/fid_pkg.sv
package fid_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_SEND,
        ST_IGNORE
    } fid_state_t;

    typedef enum logic [1:0] {
        SEQ_JEDEC,
        SEQ_PAIR,
        SEQ_DEVONLY
    } fid_seq_t;

    localparam logic [BYTE_W-1:0] OP_JEDEC = 8'h9F;
    localparam logic [BYTE_W-1:0] OP_MFDEV = 8'h90;
    localparam logic [BYTE_W-1:0] OP_RELID = 8'hAB;
endpackage

// File: rtl/fid_rx.sv
module fid_rx
    import fid_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic         rise,
    input  logic         mosi,
    output logic         byte_stb,
    output logic [W-1:0] byte_data
);
    localparam int CW = $clog2(W);

    logic [CW-1:0] bit_cnt;
    logic [W-2:0]  shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            shreg     <= '0;
            byte_stb  <= 1'b0;
            byte_data <= '0;
        end else if (cs_n) begin
            bit_cnt  <= '0;
            byte_stb <= 1'b0;
        end else begin
            byte_stb <= 1'b0;
            if (rise) begin
                shreg <= {shreg[W-3:0], mosi};
                if (bit_cnt == CW'(W-1)) begin
                    bit_cnt   <= '0;
                    byte_stb  <= 1'b1;
                    byte_data <= {shreg, mosi};
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    // R2: a byte completes on one rising edge only, never two clocks running
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb |=> !byte_stb);
endmodule

// File: rtl/fid_tx.sv
module fid_tx
    import fid_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fall,
    input  logic         active,
    input  logic [W-1:0] cur_byte,
    output logic         so_q,
    output logic         oe_q,
    output logic         byte_done
);
    localparam int IW = $clog2(W);

    logic [IW-1:0] bit_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            so_q      <= 1'b0;
            oe_q      <= 1'b0;
            bit_idx   <= IW'(W-1);
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (!active) begin
                oe_q    <= 1'b0;
                bit_idx <= IW'(W-1);
            end else if (fall) begin
                so_q <= cur_byte[bit_idx];
                oe_q <= 1'b1;
                if (bit_idx == '0) begin
                    bit_idx   <= IW'(W-1);
                    byte_done <= 1'b1;
                end else begin
                    bit_idx <= bit_idx - 1'b1;
                end
            end
        end
    end

    // R9: output bit moves only on a sampled falling SCLK
    a_r9_hold_between_falls: assert property (@(posedge clk) disable iff (!rst_n)
        !fall |=> $stable(so_q));

    // R2: drive begins at a falling edge, never mid-phase
    a_r2_enable_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_q) |-> $past(fall));
endmodule

// File: rtl/fid_ctrl.sv
module fid_ctrl
    import fid_pkg::*;
#(
    parameter int             W           = BYTE_W,
    parameter int             ADDR_BYTES  = 3,
    parameter int             DUMMY_BYTES = 3,
    parameter logic [W-1:0]   MFR_ID      = 8'h5A,
    parameter logic [W-1:0]   TYPE_ID     = 8'h40,
    parameter logic [W-1:0]   CAP_ID      = 8'h13,
    parameter logic [W-1:0]   DEV_ID      = 8'h12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic         busy,
    input  logic         byte_stb,
    input  logic [W-1:0] byte_data,
    input  logic         byte_done,
    output logic         send_active,
    output logic [W-1:0] cur_byte
);
    localparam int MAXB = (ADDR_BYTES > DUMMY_BYTES) ? ADDR_BYTES : DUMMY_BYTES;
    localparam int CNT_W = $clog2(MAXB + 1);

    fid_state_t       state, nxt;
    fid_seq_t         seq;
    logic [1:0]       ptr, ptr_next;
    logic [CNT_W-1:0] cnt, need_q;
    logic             last_in;

    assign last_in = byte_stb && (cnt == need_q - CNT_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (!cs_n) nxt = ST_OPCODE;
            ST_OPCODE: begin
                if (byte_stb) begin
                    if (byte_data == OP_JEDEC)      nxt = busy ? ST_IGNORE : ST_SEND;
                    else if (byte_data == OP_MFDEV) nxt = ST_ADDR;
                    else if (byte_data == OP_RELID) nxt = busy ? ST_IGNORE : ST_ADDR;
                    else                            nxt = ST_IGNORE;
                end
            end
            ST_ADDR:   if (last_in) nxt = ST_SEND;
            ST_SEND:   nxt = ST_SEND;
            ST_IGNORE: nxt = ST_IGNORE;
            default:   nxt = ST_IDLE;
        endcase
        if (cs_n) nxt = ST_IDLE;
    end

    // sequence pointer advance
    always_comb begin
        unique case (seq)
            SEQ_JEDEC: ptr_next = (ptr == 2'd2) ? 2'd0 : ptr + 2'd1;
            SEQ_PAIR:  ptr_next = {1'b0, ~ptr[0]};
            default:   ptr_next = 2'd0;
        endcase
    end

    // command datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq    <= SEQ_JEDEC;
            ptr    <= 2'd0;
            cnt    <= '0;
            need_q <= CNT_W'(ADDR_BYTES);
        end else if (cs_n) begin
            ptr <= 2'd0;
            cnt <= '0;
        end else begin
            unique case (state)
                ST_OPCODE: if (byte_stb) begin
                    cnt <= '0;
                    ptr <= 2'd0;
                    if (byte_data == OP_MFDEV) begin
                        seq    <= SEQ_PAIR;
                        need_q <= CNT_W'(ADDR_BYTES);
                    end else if (byte_data == OP_RELID) begin
                        seq    <= SEQ_DEVONLY;
                        need_q <= CNT_W'(DUMMY_BYTES);
                    end else begin
                        seq <= SEQ_JEDEC;
                    end
                end
                ST_ADDR: if (byte_stb) begin
                    cnt <= cnt + 1'b1;
                    if (last_in)
                        ptr <= (seq == SEQ_PAIR) ? {1'b0, byte_data[0]} : 2'd0;
                end
                ST_SEND: if (byte_done) ptr <= ptr_next;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        send_active = (state == ST_SEND);
        unique case (seq)
            SEQ_JEDEC: cur_byte = (ptr == 2'd0) ? MFR_ID :
                                  (ptr == 2'd1) ? TYPE_ID : CAP_ID;
            SEQ_PAIR:  cur_byte = ptr[0] ? DEV_ID : MFR_ID;
            default:   cur_byte = DEV_ID;
        endcase
    end

    // R4: busy identification read never reaches the send state
    a_r4_busy_jedec_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPCODE && byte_stb && !cs_n && busy && byte_data == OP_JEDEC)
        |=> state != ST_SEND);

    // R8: busy release-ID read is rejected too
    a_r8_busy_relid_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPCODE && byte_stb && !cs_n && busy && byte_data == OP_RELID)
        |=> state == ST_IGNORE);

    // R10: unknown opcode goes nowhere near the output
    a_r10_unknown_opcode: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPCODE && byte_stb && !cs_n && byte_data != OP_JEDEC &&
         byte_data != OP_MFDEV && byte_data != OP_RELID) |=> state == ST_IGNORE);

    // R11: deselect always returns to idle
    a_r11_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> state == ST_IDLE);

    // R3: a rejected command stays rejected until deselect
    a_r3_ignore_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE && !cs_n) |=> state == ST_IGNORE);
endmodule

// File: rtl/fid_responder.sv
module fid_responder
    import fid_pkg::*;
#(
    parameter int                ADDR_BYTES  = 3,
    parameter int                DUMMY_BYTES = 3,
    parameter logic [BYTE_W-1:0] MFR_ID      = 8'h5A,
    parameter logic [BYTE_W-1:0] TYPE_ID     = 8'h40,
    parameter logic [BYTE_W-1:0] CAP_ID      = 8'h13,
    parameter logic [BYTE_W-1:0] DEV_ID      = 8'h12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic mosi,
    input  logic busy,
    output logic so_data,
    output logic so_oe
);
    logic              sclk_q;
    logic              rise, fall;
    logic              byte_stb, byte_done, send_active, oe_q;
    logic [BYTE_W-1:0] byte_data, cur_byte;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    assign rise = sclk & ~sclk_q & ~cs_n;
    assign fall = ~sclk & sclk_q & ~cs_n;

    fid_rx #(.W(BYTE_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rise(rise), .mosi(mosi),
        .byte_stb(byte_stb), .byte_data(byte_data)
    );

    fid_ctrl #(
        .W(BYTE_W), .ADDR_BYTES(ADDR_BYTES), .DUMMY_BYTES(DUMMY_BYTES),
        .MFR_ID(MFR_ID), .TYPE_ID(TYPE_ID), .CAP_ID(CAP_ID), .DEV_ID(DEV_ID)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .busy(busy),
        .byte_stb(byte_stb), .byte_data(byte_data), .byte_done(byte_done),
        .send_active(send_active), .cur_byte(cur_byte)
    );

    fid_tx #(.W(BYTE_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .fall(fall), .active(send_active),
        .cur_byte(cur_byte), .so_q(so_data), .oe_q(oe_q), .byte_done(byte_done)
    );

    assign so_oe = oe_q & ~cs_n;

    // R1: never drive the pad while deselected
    a_r1_hiz_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !so_oe);
endmodule

// File: tb/fid_responder_tb.sv
module fid_responder_tb;
    localparam int HP = 4;
    localparam logic [7:0] MFR = 8'h5A, TYP = 8'h40, CAP = 8'h13, DEV = 8'h12;

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0, busy = 1'b0;
    logic so_data, so_oe;
    int   checks = 0, failures = 0;
    bit   finished = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] act_q[$];

    always #2.5 clk = ~clk;

    fid_responder u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
        .busy(busy), .so_data(so_data), .so_oe(so_oe)
    );

    task automatic check(input bit ok, input string req, input logic [7:0] act,
                         input logic [7:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, expv);
        end
    endtask

    task automatic expect_byte(input logic [7:0] b, input string req);
        exp_q.push_back(b);
        tag_q.push_back(req);
    endtask

    task automatic select();
        sclk = 1'b0; cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic deselect();
        sclk = 1'b0; cs_n = 1'b1;
        repeat (6) @(negedge clk);
        check(so_oe == 1'b0, "R1", {7'd0, so_oe}, 8'h00);
    endtask

    // shifts one byte in; the pad must stay released throughout (R2)
    task automatic send_byte(input logic [7:0] b);
        bit seen = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            sclk = 1'b0; mosi = b[i];
            repeat (HP) @(negedge clk);
            if (so_oe) seen = 1'b1;
            sclk = 1'b1;
            repeat (HP) @(negedge clk);
            if (so_oe) seen = 1'b1;
        end
        check(!seen, "R2", {7'd0, seen}, 8'h00);
    endtask

    task automatic read_byte(output logic [7:0] v, output bit oe_all, output bit oe_any,
                             output bit stable);
        oe_all = 1'b1; oe_any = 1'b0; stable = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            sclk = 1'b0;
            repeat (HP) @(negedge clk);
            v[i] = so_data;
            if (so_oe) oe_any = 1'b1; else oe_all = 1'b0;
            sclk = 1'b1;
            repeat (HP) @(negedge clk);
            if (so_data !== v[i]) stable = 1'b0;
            if (so_oe) oe_any = 1'b1; else oe_all = 1'b0;
        end
    endtask

    // driven read: result goes to the scoreboard
    task automatic read_scored(input string req);
        logic [7:0] v; bit a, n, s;
        read_byte(v, a, n, s);
        act_q.push_back(v);
        check(a, req, {7'd0, a}, 8'h01);
        check(s, "R9", {7'd0, s}, 8'h01);
    endtask

    // rejected command: nothing may be driven
    task automatic read_silent(input string req);
        logic [7:0] v; bit a, n, s;
        read_byte(v, a, n, s);
        check(!n, req, {7'd0, n}, 8'h00);
    endtask

    // monitor: compare produced bytes with the expected stream in order
    initial begin
        forever begin
            wait (act_q.size() > 0);
            begin
                logic [7:0] a, e; string t;
                a = act_q.pop_front();
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3", a, 8'h00);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(a === e, t, a, e);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(so_oe == 1'b0, "R1", {7'd0, so_oe}, 8'h00);

        // R3: full identification, including wrap to the first byte
        expect_byte(MFR, "R3"); expect_byte(TYP, "R3");
        expect_byte(CAP, "R3"); expect_byte(MFR, "R3");
        select(); send_byte(8'h9F);
        repeat (4) read_scored("R3");
        deselect();

        // R5: address bit 0 clear
        expect_byte(MFR, "R5"); expect_byte(DEV, "R5");
        expect_byte(MFR, "R5"); expect_byte(DEV, "R5");
        select(); send_byte(8'h90); send_byte(8'h00); send_byte(8'h00); send_byte(8'h00);
        repeat (4) read_scored("R5");
        deselect();

        // R6: address bit 0 set
        expect_byte(DEV, "R6"); expect_byte(MFR, "R6"); expect_byte(DEV, "R6");
        select(); send_byte(8'h90); send_byte(8'h00); send_byte(8'h00); send_byte(8'h01);
        repeat (3) read_scored("R6");
        deselect();

        // R7: device ID repeats after three dummies
        expect_byte(DEV, "R7"); expect_byte(DEV, "R7"); expect_byte(DEV, "R7");
        select(); send_byte(8'hAB); send_byte(8'hFF); send_byte(8'h00); send_byte(8'hA5);
        repeat (3) read_scored("R7");
        deselect();

        // R4: identification while busy
        busy = 1'b1;
        select(); send_byte(8'h9F);
        repeat (2) read_silent("R4");
        deselect();

        // R8: release-ID while busy
        select(); send_byte(8'hAB); send_byte(8'h00); send_byte(8'h00); send_byte(8'h00);
        repeat (2) read_silent("R8");
        deselect();
        busy = 1'b0;

        // R10: unknown opcode
        select(); send_byte(8'h05);
        repeat (2) read_silent("R10");
        deselect();

        // R11: abort mid-byte, then a clean restart
        expect_byte(MFR, "R11");
        select(); send_byte(8'h9F);
        read_scored("R11");
        for (int i = 0; i < 3; i++) begin
            sclk = 1'b0; repeat (HP) @(negedge clk);
            sclk = 1'b1; repeat (HP) @(negedge clk);
        end
        deselect();
        expect_byte(MFR, "R11"); expect_byte(TYP, "R11");
        select(); send_byte(8'h9F);
        repeat (2) read_scored("R11");
        deselect();

        wait (act_q.size() == 0);
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R3", 8'(exp_q.size()), 8'h00);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule